// File: doc/BRIEF.md
# Power-On Memory Self-Test Engine

This engine checks a sample memory as soon as reset is released, before the rest of the system uses that memory. It needs no start command. While the test runs, the engine owns the memory's single-port request/acknowledge interface. It walks the address space from the lowest location to the highest. At each location it writes a data pattern, reads it back, writes the bitwise complement, and reads that back too.

A single bad location does not fail the memory. The engine counts bad locations that occur one after another. It declares failure only when that run reaches a configurable threshold, which defaults to nine. A good location sets the run back to zero. When the threshold is reached the test ends at that location. If the last address is checked without such a run, the test ends with a pass. In both cases `test_done` rises, and a two-bit status code selects what the display shows. That code stays frozen until the next reset.

Top module: `mem_selftest_top`

## Requirements
- R1: After reset is released the test begins with no further input. `test_done` is 0, `test_status` is 2'b00 (running), and the first request targets address 0.
- R2: Locations are visited in ascending order, 0 to 2^ADDR_W-1. The engine never advances past the last address.
- R3: Each visited location gets exactly two writes, a pattern first and then its bitwise complement. Each write is followed by exactly one read of the same address.
- R4: Read data is taken from `mem_rdata` in the cycle right after the cycle in which `mem_ack` is high, and not from any other cycle.
- R5: Once `mem_req` is raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is seen high.
- R6: A location is bad if either readback differs from the value written. The count of consecutive bad locations returns to 0 on any good location and never exceeds FAIL_RUN. When it reaches FAIL_RUN, the test stops and no higher address is accessed.
- R7: If no run of FAIL_RUN consecutive bad locations occurs, the test ends after the last address with `test_status` = 2'b01 (pass). This holds even when shorter runs or isolated bad locations exist.
- R8: If a run of FAIL_RUN consecutive bad locations occurs, `test_status` = 2'b10 (error indication).
- R9: Once `test_done` is 1, it stays 1, `test_status` does not change, and `mem_req` stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; releasing it starts the test |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Location being accessed |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | One-cycle acknowledge from the memory |
| mem_rdata | input | DATA_W | Read data, valid in the cycle after the acknowledge |
| test_done | output | 1 | High once the verdict is final |
| test_status | output | 2 | 00 running, 01 pass, 10 error |

## Verification
The bench places runs of bad locations at the exact threshold boundary: eight in a row must pass and nine in a row must fail. It also puts the nine at the very start and at the very end of memory, and splits two runs of five with one good location. A counter that is off by one, that fails to clear, or that mishandles the last address would give the wrong verdict in one of these cases. The memory model returns inverted data on every cycle except the valid one, and adds random acknowledge delays. An engine that samples read data on the wrong cycle would therefore report a clean memory as bad, and one that drops a request early would be caught changing its address or data mid-handshake. After each case the bench counts writes and reads per address. This catches an engine that skips the complement pass, revisits locations, or keeps going past the failing run.

// File: rtl/mst_pkg.sv
package mst_pkg;

    typedef enum logic [2:0] {
        ST_WR_PAT,
        ST_RD_PAT,
        ST_CHK_PAT,
        ST_WR_INV,
        ST_RD_INV,
        ST_CHK_INV,
        ST_DONE
    } mst_state_e;

    localparam logic [1:0] STATUS_RUN  = 2'b00;
    localparam logic [1:0] STATUS_PASS = 2'b01;
    localparam logic [1:0] STATUS_ERR  = 2'b10;

endpackage

// File: rtl/mst_addr_seq.sv
module mst_addr_seq #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (step_i && (addr_q != LAST_ADDR)) begin
            addr_d = addr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;
    assign last_o = (addr_q == LAST_ADDR);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !last_o) |=> (addr_o == $past(addr_o) + ADDR_W'(1))); // R2
    AST_ADDR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> last_o); // R2

endmodule

// File: rtl/mst_pattern_gen.sv
module mst_pattern_gen #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              invert_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] base;

    // Alternating checkerboard, flipped per address bit so neighbours differ.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign base[i] = 1'(i % 2) ^ addr_i[i % ADDR_W];
    end

    always_comb begin
        data_o = invert_i ? ~base : base;
    end

endmodule

// File: rtl/mst_fail_run.sv
module mst_fail_run #(
    parameter int FAIL_RUN = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic update_i,
    input  logic bad_i,
    output logic hit_o
);
    localparam int CNT_W = $clog2(FAIL_RUN + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FAIL_RUN);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (update_i) begin
            if (!bad_i) begin
                cnt_d = '0;
            end else if (cnt_q != LIMIT) begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit_o = update_i && bad_i && (cnt_q >= LIMIT - CNT_W'(1));

    AST_RUN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT); // R6
    AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (update_i && !bad_i) |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/mem_selftest_top.sv
module mem_selftest_top
    import mst_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 8,
    parameter int FAIL_RUN = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              test_done,
    output logic [1:0]        test_status
);
    typedef struct packed {
        mst_state_e state;
        logic       err;
        logic [1:0] status;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic              step;
    logic              invert;
    logic              upd;
    logic              bad;
    logic              hit;
    logic              last;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] pat;

    mst_addr_seq #(.ADDR_W(ADDR_W)) i_addr_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .addr_o (addr),
        .last_o (last)
    );

    mst_pattern_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pattern (
        .addr_i   (addr),
        .invert_i (invert),
        .data_o   (pat)
    );

    mst_fail_run #(.FAIL_RUN(FAIL_RUN)) i_fail_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .update_i (upd),
        .bad_i    (bad),
        .hit_o    (hit)
    );

    always_comb begin
        nxt_d   = cur_q;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        invert  = 1'b0;
        step    = 1'b0;
        upd     = 1'b0;
        bad     = 1'b0;
        unique case (cur_q.state)
            ST_WR_PAT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) nxt_d.state = ST_RD_PAT;
            end
            ST_RD_PAT: begin
                mem_req = 1'b1;
                if (mem_ack) nxt_d.state = ST_CHK_PAT;
            end
            ST_CHK_PAT: begin
                nxt_d.err   = (mem_rdata != pat);
                nxt_d.state = ST_WR_INV;
            end
            ST_WR_INV: begin
                invert  = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) nxt_d.state = ST_RD_INV;
            end
            ST_RD_INV: begin
                invert  = 1'b1;
                mem_req = 1'b1;
                if (mem_ack) nxt_d.state = ST_CHK_INV;
            end
            ST_CHK_INV: begin
                invert = 1'b1;
                upd    = 1'b1;
                bad    = cur_q.err || (mem_rdata != pat);
                if (hit) begin
                    nxt_d.state  = ST_DONE;
                    nxt_d.status = STATUS_ERR;
                end else if (last) begin
                    nxt_d.state  = ST_DONE;
                    nxt_d.status = STATUS_PASS;
                end else begin
                    step        = 1'b1;
                    nxt_d.state = ST_WR_PAT;
                end
            end
            default: begin
                nxt_d.state = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_WR_PAT, err: 1'b0, status: STATUS_RUN};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_addr    = addr;
    assign mem_wdata   = pat;
    assign test_done   = (cur_q.state == ST_DONE);
    assign test_status = cur_q.status;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |=> (test_done && $stable(test_status))); // R9
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |-> !mem_req); // R9
    AST_VERDICT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_done) |-> (test_status != STATUS_RUN)); // R7

endmodule

// File: tb/test_mem_selftest_top.sv
module test_mem_selftest_top;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int RUN   = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          test_done;
    logic [1:0]    test_status;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mem_selftest_top #(.ADDR_W(AW), .DATA_W(DW), .FAIL_RUN(RUN)) i_mem_selftest_top (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .test_done(test_done), .test_status(test_status)
    );

    // Memory model with fault map and optional random wait states
    logic [DW-1:0] mem [DEPTH];
    logic [DEPTH-1:0] bad_map;
    logic          jitter;
    logic [DW-1:0] rd_hold;
    logic          rd_pend;
    int            wr_cnt [DEPTH];
    int            rd_cnt [DEPTH];
    logic [DW-1:0] first_w [DEPTH];
    int            pair_err, order_err, hold_err, late_req;
    int            last_a;
    logic          p_chk, p_we;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            rd_pend   <= 1'b0;
            p_chk     <= 1'b0;
        end else begin
            logic grant;
            grant = mem_req && !mem_ack && (!jitter || ($urandom_range(0, 2) == 0));
            if (p_chk && (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_wd))
                hold_err++;
            if (test_done && mem_req) late_req++;
            p_chk  <= mem_req && !mem_ack && !grant;
            p_addr <= mem_addr;
            p_we   <= mem_we;
            p_wd   <= mem_wdata;
            mem_ack   <= grant;
            rd_pend   <= 1'b0;
            mem_rdata <= rd_pend ? rd_hold : ~rd_hold;
            if (grant) begin
                if (int'(mem_addr) < last_a) order_err++;
                last_a = int'(mem_addr);
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    if (wr_cnt[mem_addr] == 0) first_w[mem_addr] <= mem_wdata;
                    else if (mem_wdata != ~first_w[mem_addr]) pair_err++;
                    wr_cnt[mem_addr]++;
                end else begin
                    rd_hold <= mem[mem_addr] ^ (bad_map[mem_addr] ? 8'h10 : 8'h00);
                    rd_pend <= 1'b1;
                    rd_cnt[mem_addr]++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart(input bit jit, input logic [DEPTH-1:0] map);
        rst_n = 1'b0;
        jitter = jit;
        bad_map = map;
        for (int a = 0; a < DEPTH; a++) begin
            wr_cnt[a] = 0; rd_cnt[a] = 0; mem[a] = '0;
        end
        pair_err = 0; order_err = 0; hold_err = 0; late_req = 0; last_a = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!test_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(test_done == 1'b1, "R9 done reached", int'(test_done), 1);
    endtask

    function automatic logic [DEPTH-1:0] span(input int lo, input int hi);
        logic [DEPTH-1:0] m = '0;
        for (int a = lo; a <= hi; a++) m[a] = 1'b1;
        return m;
    endfunction

    // Checks per-address access counts up to the stop address and quiet beyond it
    task automatic check_case(input string tag, input logic [1:0] exp_st, input int stop);
        int miss = 0;
        logic [1:0] st;
        for (int a = 0; a < DEPTH; a++) begin
            int e = (a <= stop) ? 2 : 0;
            if (wr_cnt[a] != e || rd_cnt[a] != e) miss++;
        end
        chk(test_status == exp_st, {tag, " R7/R8 verdict"}, int'(test_status), int'(exp_st));
        chk(miss == 0, {tag, " R2/R6 addresses touched"}, miss, 0);
        chk(pair_err == 0, {tag, " R3 pattern then complement"}, pair_err, 0);
        chk(order_err == 0, {tag, " R2 ascending order"}, order_err, 0);
        chk(hold_err == 0, {tag, " R5 request held"}, hold_err, 0);
        st = test_status;
        repeat (30) @(negedge clk);
        chk(test_done && test_status == st && late_req == 0, {tag, " R9 frozen"},
            int'(test_status) + 10 * late_req, int'(st));
    endtask

    task automatic t_reset();
        restart(1'b0, '0);
        chk(test_done == 1'b0, "R1 done low", int'(test_done), 0);
        chk(test_status == 2'b00, "R1 running status", int'(test_status), 0);
        chk(mem_req && mem_we && mem_addr == '0, "R1 auto start at 0", int'(mem_addr), 0);
        wait_done();
    endtask

    task automatic t_clean();
        restart(1'b0, '0);
        wait_done();
        check_case("clean R4", 2'b01, DEPTH - 1);
    endtask

    task automatic t_jitter();
        restart(1'b1, '0);
        wait_done();
        check_case("wait-states R4 R5", 2'b01, DEPTH - 1);
    endtask

    task automatic t_run_short();
        restart(1'b0, span(20, 27));
        wait_done();
        check_case("eight bad R7", 2'b01, DEPTH - 1);
    endtask

    task automatic t_run_full();
        restart(1'b0, span(20, 28));
        wait_done();
        check_case("nine bad R6 R8", 2'b10, 28);
    endtask

    task automatic t_broken();
        restart(1'b1, span(10, 14) | span(16, 20) | span(40, 40));
        wait_done();
        check_case("split runs R6 R7", 2'b01, DEPTH - 1);
    endtask

    task automatic t_head();
        restart(1'b1, span(0, 8));
        wait_done();
        check_case("head run R6", 2'b10, 8);
    endtask

    task automatic t_tail();
        restart(1'b0, span(DEPTH - 9, DEPTH - 1));
        wait_done();
        check_case("tail run R2 R8", 2'b10, DEPTH - 1);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        jitter = 1'b0;
        bad_map = '0;
        t_reset();
        t_clean();
        t_jitter();
        t_run_short();
        t_run_full();
        t_broken();
        t_head();
        t_tail();
        finish_run();
    end

endmodule